// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x oversampling tick for a serial receiver and transmitter from the system clock. Software loads an integer divisor and a fractional divisor. The fractional divisor is `FRAC_W` bits wide. The block then emits a one-cycle tick whose average spacing is `div_int + div_frac / 2^FRAC_W` clock cycles.

The fraction is spread over successive periods by an F-bit phase accumulator. At the end of each integer period the fraction is added to the accumulator. When that addition carries out, the period is stretched by exactly one clock.

Software finds the fraction width by writing all ones to the fraction register and reading it back. Only the implemented bits return ones. A read of zero after that write would mean the block has no fractional support.

The sequencing lives in a small state machine with three states:
- **HALT**: the counter is stopped and there is no tick. The machine is in HALT after reset, after any register write, and whenever the integer divisor is zero.
- **COUNT**: the cycle counter runs from 1 up to the integer divisor.
- **STRETCH**: the single extra clock of a carried period.

The transitions are:
- **HALT→COUNT** (start): taken when the integer divisor is nonzero.
- **COUNT→COUNT** (advance, or wrap with a tick): the counter steps, or the period ends without a carry.
- **COUNT→STRETCH** (carry): the period ends and the accumulator carries out.
- **STRETCH→COUNT** (resume): the tick is given and the next period starts.
- **COUNT→HALT**: taken when the integer divisor is zero.
- **any→HALT** (restart): taken on every register write.

Top module: `fbaud_gen`

## Requirements
- R1: After reset `tick` is low, and both registers read zero. Address 0 selects the integer divisor and address 1 selects the fraction.
- R2: The integer divisor register (address 0) reads back all `INT_W` bits that were written to it.
- R3: The fraction register (address 1) holds only its low `FRAC_W` bits, and its upper read bits are zero. With the default `FRAC_W`=4, writing 0xFFFF reads back 0x000F.
- R4: With a fraction of zero and a divisor D ≥ 1, ticks come exactly D cycles apart.
- R5: With a nonzero fraction f, each period is D cycles, or D+1 when the running F-bit sum of f (starting at 0 after a restart) overflows in that period.
- R6: Over 2^F consecutive periods, the total number of cycles equals D·2^F + f.
- R7: When D ≥ 2, `tick` is high for one cycle only and never for two cycles in a row.
- R8: An integer divisor of zero keeps `tick` low.
- R9: A write to either register restarts the counter and clears the accumulator. The first tick after the write comes one period (D, or D+1 on a carry) after the write edge.
- R10: Every fraction value from 0 to 2^F−1 is accepted, including all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write select: 0 integer, 1 fraction |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read select: 0 integer, 1 fraction |
| rd_data | output | DATA_W | Read data, combinational |
| tick | output | 1 | One-cycle oversampling tick |

## Verification
The assertions assume that the divisor registers change only through a write strobe. Each such write forces HALT on the same edge, so the counter can never be compared against a divisor that changed under it. The stimulus changes the divisors only through the write task, and never drives `wr_en` for longer than one clock per access. The bench samples periods only after a complete write has settled, so every measured period starts from a known restart with a cleared accumulator.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } fb_state_t;

    localparam logic SEL_INT  = 1'b0;
    localparam logic SEL_FRAC = 1'b1;

endpackage

// File: rtl/fbaud_regs.sv
module fbaud_regs
    import fbaud_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac,
    output logic              restart
);

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [DATA_W-1:0] int_rd;
    logic [DATA_W-1:0] frac_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == SEL_INT) begin
                int_q <= wr_data[INT_W-1:0];
            end else begin
                frac_q <= wr_data[FRAC_W-1:0];
            end
        end
    end

    generate
        if (DATA_W > INT_W) begin : g_int_pad
            assign int_rd = {{(DATA_W-INT_W){1'b0}}, int_q};
        end else begin : g_int_full
            assign int_rd = int_q;
        end
        if (DATA_W > FRAC_W) begin : g_frac_pad
            assign frac_rd = {{(DATA_W-FRAC_W){1'b0}}, frac_q};
        end else begin : g_frac_full
            assign frac_rd = frac_q;
        end
    endgenerate

    always_comb begin
        rd_data = (rd_addr == SEL_INT) ? int_rd : frac_rd;
    end

    assign div_int  = int_q;
    assign div_frac = frac_q;
    assign restart  = wr_en;

    // R3
    frac_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_FRAC) |=> (div_frac == $past(wr_data[FRAC_W-1:0])));

    // R2
    int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_INT) |=> (div_int == $past(wr_data[INT_W-1:0])));

endmodule

// File: rtl/fbaud_accum.sv
module fbaud_accum #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(acc_q));

endmodule

// File: rtl/fbaud_ctrl.sv
module fbaud_ctrl
    import fbaud_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [INT_W-1:0] div_int,
    input  logic             carry,
    output logic             step,
    output logic             tick
);

    fb_state_t        state_q, state_d;
    logic [INT_W-1:0] cnt_q, cnt_d;
    logic             at_end;

    assign at_end = (state_q == ST_COUNT) && (cnt_q == div_int);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HALT: begin
                if (div_int != '0) begin
                    state_d = ST_COUNT;
                    cnt_d   = INT_W'(1);
                end
            end
            ST_COUNT: begin
                if (div_int == '0) begin
                    state_d = ST_HALT;
                end else if (at_end) begin
                    cnt_d   = INT_W'(1);
                    state_d = carry ? ST_STRETCH : ST_COUNT;
                end else begin
                    cnt_d = cnt_q + INT_W'(1);
                end
            end
            ST_STRETCH: begin
                state_d = ST_COUNT;
                cnt_d   = INT_W'(1);
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
        if (restart) begin
            state_d = ST_HALT;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        step = at_end && !restart;
        tick = (at_end && !carry) || (state_q == ST_STRETCH);
    end

    // R8
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_int == '0) |-> !tick);

    // R7
    stretch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |=> (state_q != ST_STRETCH));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q != '0 && cnt_q <= div_int));

    // R9
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q == ST_HALT && !tick));

endmodule

// File: rtl/fbaud_gen.sv
module fbaud_gen #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick
);

    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              restart;
    logic              step;
    logic              carry;

    fbaud_regs #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .div_int (div_int),
        .div_frac(div_frac),
        .restart (restart)
    );

    fbaud_accum #(
        .FRAC_W(FRAC_W)
    ) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(restart),
        .step (step),
        .frac (div_frac),
        .carry(carry)
    );

    fbaud_ctrl #(
        .INT_W(INT_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .div_int(div_int),
        .carry  (carry),
        .step   (step),
        .tick   (tick)
    );

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_int > INT_W'(1)) |=> !tick);

endmodule

// File: tb/fbaud_gen_bench.sv
module fbaud_gen_bench;

    localparam int CLK_P  = 10;
    localparam int FRAC_W = 4;
    localparam int NPER   = 1 << FRAC_W;
    localparam int VEC_N  = 6;

    localparam int VEC_DIV  [VEC_N] = '{3, 3, 4, 1, 2, 7};
    localparam int VEC_FRAC [VEC_N] = '{0, 5, 15, 8, 1, 10};
    localparam int VEC_SUM  [VEC_N] = '{48, 53, 79, 24, 33, 122};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic        tick;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    fbaud_gen u_fbaud_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .tick   (tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic measure(output int len);
        len = 0;
        do begin
            @(posedge clk);
            len++;
            @(negedge clk);
        end while (!tick && len < 2000);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v;
        int len;
        int acc;
        int total;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tick", int'(tick), 0);
        rd(1'b0, v); chk("R1 int reg", v, 0);
        rd(1'b1, v); chk("R1 frac reg", v, 0);

        // R2 integer readback
        wr(1'b0, 16'hA5C3);
        rd(1'b0, v); chk("R2 int readback", v, 16'hA5C3);

        // R3 fraction width discovery
        wr(1'b1, 16'hFFFF);
        rd(1'b1, v); chk("R3 frac readback", v, 16'h000F);

        // R8 zero divisor stops ticks
        wr(1'b0, 16'h0000);
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick) hi++;
        end
        chk("R8 ticks with zero divisor", hi, 0);

        // Vector table: R4 R5 R6 R10
        for (int k = 0; k < VEC_N; k++) begin
            wr(1'b0, 16'(VEC_DIV[k]));
            wr(1'b1, 16'(VEC_FRAC[k]));
            acc = 0;
            total = 0;
            for (int p = 0; p < NPER; p++) begin
                int expl;
                measure(len);
                acc = acc + VEC_FRAC[k];
                expl = VEC_DIV[k] + ((acc >= NPER) ? 1 : 0);
                acc = acc % NPER;
                total += len;
                if (VEC_FRAC[k] == 0) chk("R4 period", len, expl);
                else chk("R5 period", len, expl);
            end
            chk("R6 total over 2^F periods", total, VEC_SUM[k]);
        end

        // R7 single-cycle tick with D=2
        wr(1'b1, 16'd0);
        wr(1'b0, 16'd2);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick) begin
                @(negedge clk);
                if (tick) hi++;
            end
        end
        chk("R7 back-to-back ticks", hi, 0);

        // R9 restart mid-period with integer write
        wr(1'b0, 16'd10);
        repeat (4) @(negedge clk);
        wr(1'b0, 16'd10);
        measure(len);
        chk("R9 first period after int write", len, 10);

        // R9 accumulator cleared on fraction write
        wr(1'b0, 16'd3);
        wr(1'b1, 16'd5);
        measure(len);
        measure(len);
        wr(1'b1, 16'd5);
        measure(len); chk("R9 period1 after frac write", len, 3);
        measure(len); chk("R9 period2 after frac write", len, 3);
        measure(len); chk("R9 period3 after frac write", len, 3);
        measure(len); chk("R9 period4 after frac write", len, 4);

        // R10 max fraction with D=1
        wr(1'b0, 16'd1);
        wr(1'b1, 16'd15);
        total = 0;
        for (int p = 0; p < NPER; p++) begin
            measure(len);
            total += len;
        end
        chk("R10 total with all-ones fraction", total, 31);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule